// File: doc/BRIEF.md
# Disk Controller Register Bank

This block is the host-facing register file of a multi-drive disk controller. The host reaches eight 32-bit registers through a simple synchronous port indexed by a 3-bit register number. The control/status register (index 0) mixes latched state with live drive state. The ready bit and the drive-type bit are re-evaluated on every access for the drive being addressed. The same register also holds the error flags, per-drive attention flags, an interrupt flag and a set of host-writable control fields. Two clearing rules apply: some bits clear when the host writes 1 to them, and one clears when the host writes 0. A mode bit chooses which of the write-one-to-clear bits are affected.

Index 1 holds the buffer address, index 2 the byte count and index 3 the disk address. Index 4 is a short queue: a host write loads every entry, and each host read returns the head and moves the others forward. Indices 5 and 6 are reserved. A host write to index 7 returns the whole bank to its reset state.

A host write that starts a command raises a one-cycle start strobe with the function and drive fields. The command sequencer sits outside this block. It reports completion with error and attention flags, sets a sticky flag, and loads the queue with status words.

Top module: `dskc_regbank`

## Requirements
- R1: After `rst_n` low, or one cycle after any host write to index 7, the control/status register reads DONE (bit 7) plus live bits only. Buffer address, byte count, disk address and all queue entries read 0, and `irq` and `cmd_start` are low.
- R2: On every access to index 0, bit 0 (ready) is recomputed as "drive enabled and not busy", and bit 26 as the drive's large-type flag. The drive is the one in write-data bits [9:8] on a write, or in the stored bits [9:8] on a read. A drive index of NUM_DRIVES or more reads as not ready and not large.
- R3: A host write to index 0 copies the write data into bits [3:1] (function), 6 (IE), 7 (DONE), [9:8] (drive), 22, 25, 27, 28, 29 and 31 (attention-mask mode). Every other bit keeps its state unless R4, R5 or R6 changes it.
- R4: While bit 31 is 0 before the write, writing 1 to bit 24 (IRQ flag) or to any of bits [19:16] (attention, one per drive) clears that bit. While bit 31 is already 1, only bit 24 clears this way. Any write whose data has a bit of [19:16] set drops `irq`.
- R5: Bit 23 (sticky flag) is set by `seq_sticky`. A host write with data bit 23 equal to 0 clears it, and a write with 1 leaves it set.
- R6: A write to index 0 with data bit 7 = 0, whose data drive is not busy, starts a command. `cmd_start` is high for exactly the next cycle with `cmd_func` = data[3:1] and `cmd_drive` = data[9:8]. The write clears bits 10, 11, 13, 14 and 15 (bit 12 is kept) and drops `irq`. With data bit 7 = 1, or a busy drive, there is no start and no error bit changes.
- R7: `seq_done` sets DONE, bit 24, bits [14:10] from `seq_err[4:0]`, and bits [19:16] from `seq_atn`. It sets `irq` to the IE bit. `irq` rises only after a `seq_done`.
- R8: Any access to index 0 forces bit 15 (error summary) to 1 when any of bits 10, 11, 13 or 14 is set.
- R9: The buffer address keeps only its low BA_BITS (18) bits and reads 0 above them. Byte count and disk address keep all 32 bits.
- R10: A host write to index 4 loads every queue entry. Each host read of index 4 returns the head and moves each later entry one place forward, and the last entry keeps its value. `seq_mp_load` loads the head with `seq_mp_data` and either clears the other entries (`seq_mp_head_only` = 1) or loads them all with the same word.
- R11: Indices 5 and 6 read 0 and ignore writes.
- R12: Read data appears on `bus_rdata` in the cycle after the read is accepted and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| drv_busy | input | NUM_DRIVES | Drive has an operation in flight |
| drv_enabled | input | NUM_DRIVES | Drive present and enabled |
| drv_is_large | input | NUM_DRIVES | Drive is of the large type |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_err | input | 5 | Error flags for bits 14:10 on completion |
| seq_atn | input | 4 | Attention flags for bits 19:16 on completion |
| seq_sticky | input | 1 | Sets the sticky flag (bit 23) |
| seq_mp_load | input | 1 | Sequencer loads the queue |
| seq_mp_head_only | input | 1 | On load, zero the entries behind the head |
| seq_mp_data | input | 32 | Queue load word |
| cmd_start | output | 1 | One-cycle command start strobe |
| cmd_func | output | 3 | Stored function field |
| cmd_drive | output | 2 | Stored drive field |
| irq | output | 1 | Interrupt request |

## Verification
Most of the state in this bank shows at the ports within a cycle or two. A wrong bit in the status word appears on the next read of index 0. A missed error clear, or a wrong clear-mode choice, shows as a stale flag on that read. A stuck or misaligned queue entry surfaces only after one or more reads have moved it to the head. The bench reaches each later entry by reading the queue several times in a row. A wrong interrupt decision shows on `irq` one cycle after the completion or write that should have moved it. A wrong start decision shows as a missing or extra `cmd_start` pulse in that same cycle.

// File: rtl/dskc_pkg.sv
`timescale 1ns/1ps
package dskc_pkg;

   // Control/status bit positions (fixed: software decodes them)
   localparam int CS_DRDY    = 0;
   localparam int CS_FUNC_LO = 1;
   localparam int CS_IE      = 6;
   localparam int CS_DONE    = 7;
   localparam int CS_DRV_LO  = 8;
   localparam int CS_E_INC   = 10;
   localparam int CS_E_CRC   = 11;
   localparam int CS_E_LATE  = 12;
   localparam int CS_E_NXM   = 13;
   localparam int CS_E_DRV   = 14;
   localparam int CS_ESUM    = 15;
   localparam int CS_ATN_LO  = 16;
   localparam int CS_OPT0    = 22;
   localparam int CS_STKY    = 23;
   localparam int CS_IRQF    = 24;
   localparam int CS_OPT1    = 25;
   localparam int CS_DTYPE   = 26;
   localparam int CS_OPT2    = 27;
   localparam int CS_OPT3    = 28;
   localparam int CS_OPT4    = 29;
   localparam int CS_AMODE   = 31;

   localparam logic [31:0] CS_ATN_BITS = 32'h000F_0000;
   localparam logic [31:0] CS_IRQ_BIT  = 32'h0100_0000;

   // Fields the host writes directly
   localparam logic [31:0] CS_WMASK =
      (32'h7 << CS_FUNC_LO) | (32'h1 << CS_IE) | (32'h1 << CS_DONE) |
      (32'h3 << CS_DRV_LO)  | (32'h1 << CS_OPT0) | (32'h1 << CS_OPT1) |
      (32'h1 << CS_OPT2)    | (32'h1 << CS_OPT3) | (32'h1 << CS_OPT4) |
      (32'h1 << CS_AMODE);

   // Bits cleared by a command start (data-late is kept)
   localparam logic [31:0] CS_ERR_CLR =
      (32'h1 << CS_E_INC) | (32'h1 << CS_E_CRC) | (32'h1 << CS_E_NXM) |
      (32'h1 << CS_E_DRV) | (32'h1 << CS_ESUM);

   // Bits that force the error summary on access
   localparam logic [31:0] CS_ERR_SRC =
      (32'h1 << CS_E_INC) | (32'h1 << CS_E_CRC) | (32'h1 << CS_E_NXM) |
      (32'h1 << CS_E_DRV);

   localparam logic [31:0] CS_RESET_VAL = 32'h1 << CS_DONE;

   typedef enum logic [2:0] {
      RI_CSR   = 3'd0,
      RI_BADDR = 3'd1,
      RI_BCNT  = 3'd2,
      RI_DADDR = 3'd3,
      RI_MPQ   = 3'd4,
      RI_RSV5  = 3'd5,
      RI_RSV6  = 3'd6,
      RI_INIT  = 3'd7
   } reg_idx_e;

endpackage

// File: rtl/dskc_csr.sv
`timescale 1ns/1ps
module dskc_csr
   import dskc_pkg::*;
#(
   parameter int NUM_DRIVES = 4
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc,
   input  logic                  wr,
   input  logic                  soft_rst,
   input  logic [31:0]           wdata,
   input  logic [NUM_DRIVES-1:0] drv_busy,
   input  logic [NUM_DRIVES-1:0] drv_enabled,
   input  logic [NUM_DRIVES-1:0] drv_is_large,
   input  logic                  seq_done,
   input  logic [4:0]            seq_err,
   input  logic [3:0]            seq_atn,
   input  logic                  seq_sticky,
   output logic [31:0]           cs_q,
   output logic [31:0]           cs_view,
   output logic                  start_q,
   output logic                  irq_q
);

   localparam int SLOTS = 4;

   logic [SLOTS-1:0] busy_p, en_p, large_p;

   // Pad drive state to the full 2-bit drive field
   for (genvar i = 0; i < SLOTS; i++) begin : g_pad
      if (i < NUM_DRIVES) begin : g_real
         assign busy_p[i]  = drv_busy[i];
         assign en_p[i]    = drv_enabled[i];
         assign large_p[i] = drv_is_large[i];
      end else begin : g_absent
         assign busy_p[i]  = 1'b0;
         assign en_p[i]    = 1'b0;
         assign large_p[i] = 1'b0;
      end
   end

   logic [31:0] nxt, clr1;
   logic [1:0]  dsel;
   logic        start, irq_n;

   always_comb begin
      nxt   = cs_q;
      start = 1'b0;
      irq_n = irq_q;
      dsel  = wr ? wdata[CS_DRV_LO +: 2] : cs_q[CS_DRV_LO +: 2];
      clr1  = cs_q[CS_AMODE] ? CS_IRQ_BIT : (CS_IRQ_BIT | CS_ATN_BITS);

      // live bits and error summary on any access
      if (acc) begin
         if (|(cs_q & CS_ERR_SRC)) nxt[CS_ESUM] = 1'b1;
         nxt[CS_DRDY]  = en_p[dsel] & ~busy_p[dsel];
         nxt[CS_DTYPE] = large_p[dsel];
      end
      cs_view = nxt;

      if (acc && wr) begin
         nxt = nxt & ~(wdata & clr1);
         if (!wdata[CS_STKY]) nxt[CS_STKY] = 1'b0;
         nxt = (nxt & ~CS_WMASK) | (wdata & CS_WMASK);
         if (|(wdata & CS_ATN_BITS)) irq_n = 1'b0;
         if (!wdata[CS_DONE] && !busy_p[dsel]) begin
            start = 1'b1;
            nxt   = nxt & ~CS_ERR_CLR;
            irq_n = 1'b0;
         end
      end

      if (seq_sticky) nxt[CS_STKY] = 1'b1;

      if (seq_done) begin
         nxt[CS_E_DRV:CS_E_INC]     = nxt[CS_E_DRV:CS_E_INC] | seq_err;
         nxt[CS_ATN_LO +: 4]        = nxt[CS_ATN_LO +: 4] | seq_atn;
         nxt[CS_DONE]               = 1'b1;
         nxt[CS_IRQF]               = 1'b1;
         irq_n                      = nxt[CS_IE];
      end

      if (soft_rst) begin
         nxt   = CS_RESET_VAL;
         irq_n = 1'b0;
         start = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q    <= CS_RESET_VAL;
         start_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         cs_q    <= nxt;
         start_q <= start;
         irq_q   <= irq_n;
      end
   end

endmodule

// File: rtl/dskc_xfer_regs.sv
`timescale 1ns/1ps
module dskc_xfer_regs #(
   parameter int BA_BITS = 18
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         wr_ba,
   input  logic         wr_bc,
   input  logic         wr_da,
   input  logic [31:0]  wdata,
   output logic [31:0]  ba,
   output logic [31:0]  bc,
   output logic [31:0]  da
);

   logic [BA_BITS-1:0] ba_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         ba_q <= '0;
         bc   <= '0;
         da   <= '0;
      end else begin
         if (wr_ba) ba_q <= wdata[BA_BITS-1:0];
         if (wr_bc) bc   <= wdata;
         if (wr_da) da   <= wdata;
      end
   end

   // zero-extend the narrow address register
   if (BA_BITS < 32) begin : g_narrow
      assign ba = {{(32-BA_BITS){1'b0}}, ba_q};
   end else begin : g_full
      assign ba = ba_q;
   end

endmodule

// File: rtl/dskc_mpq.sv
`timescale 1ns/1ps
module dskc_mpq #(
   parameter int DEPTH = 3
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        host_load,
   input  logic [31:0] host_data,
   input  logic        seq_load,
   input  logic        seq_head_only,
   input  logic [31:0] seq_data,
   input  logic        pop,
   output logic [31:0] head
);

   logic [31:0] q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [31:0] from_next;
      if (i == DEPTH - 1) begin : g_tail
         assign from_next = q[i];
      end else begin : g_mid
         assign from_next = q[i+1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n || clr)     q[i] <= '0;
         else if (host_load)    q[i] <= host_data;
         else if (seq_load)     q[i] <= (i != 0 && seq_head_only) ? 32'h0 : seq_data;
         else if (pop)          q[i] <= from_next;
      end
   end

   assign head = q[0];

endmodule

// File: rtl/dskc_regbank.sv
`timescale 1ns/1ps
module dskc_regbank
   import dskc_pkg::*;
#(
   parameter int NUM_DRIVES = 4,
   parameter int BA_BITS    = 18,
   parameter int MPQ_DEPTH  = 3
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [2:0]            bus_addr,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [NUM_DRIVES-1:0] drv_busy,
   input  logic [NUM_DRIVES-1:0] drv_enabled,
   input  logic [NUM_DRIVES-1:0] drv_is_large,
   input  logic                  seq_done,
   input  logic [4:0]            seq_err,
   input  logic [3:0]            seq_atn,
   input  logic                  seq_sticky,
   input  logic                  seq_mp_load,
   input  logic                  seq_mp_head_only,
   input  logic [31:0]           seq_mp_data,
   output logic                  cmd_start,
   output logic [2:0]            cmd_func,
   output logic [1:0]            cmd_drive,
   output logic                  irq
);

   // elaboration-time parameter checks
   if (NUM_DRIVES < 1 || NUM_DRIVES > 4) begin : g_bad_drives
      $error("NUM_DRIVES must be 1..4");
   end
   if (BA_BITS < 1 || BA_BITS > 32) begin : g_bad_ba
      $error("BA_BITS must be 1..32");
   end
   if (MPQ_DEPTH < 1 || MPQ_DEPTH > 16) begin : g_bad_depth
      $error("MPQ_DEPTH must be 1..16");
   end

   logic rd_acc, wr_acc;
   logic [31:0] cs_q, cs_view, ba, bc, da, mp_head;
   logic soft_rst;

   assign rd_acc   = bus_sel && !bus_wr;
   assign wr_acc   = bus_sel &&  bus_wr;
   assign soft_rst = wr_acc && (bus_addr == RI_INIT);

   dskc_csr #(.NUM_DRIVES(NUM_DRIVES)) u_csr (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc          (bus_sel && bus_addr == RI_CSR),
      .wr           (bus_wr),
      .soft_rst     (soft_rst),
      .wdata        (bus_wdata),
      .drv_busy     (drv_busy),
      .drv_enabled  (drv_enabled),
      .drv_is_large (drv_is_large),
      .seq_done     (seq_done),
      .seq_err      (seq_err),
      .seq_atn      (seq_atn),
      .seq_sticky   (seq_sticky),
      .cs_q         (cs_q),
      .cs_view      (cs_view),
      .start_q      (cmd_start),
      .irq_q        (irq)
   );

   dskc_xfer_regs #(.BA_BITS(BA_BITS)) u_xfer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_rst),
      .wr_ba (wr_acc && bus_addr == RI_BADDR),
      .wr_bc (wr_acc && bus_addr == RI_BCNT),
      .wr_da (wr_acc && bus_addr == RI_DADDR),
      .wdata (bus_wdata),
      .ba    (ba),
      .bc    (bc),
      .da    (da)
   );

   dskc_mpq #(.DEPTH(MPQ_DEPTH)) u_mpq (
      .clk           (clk),
      .rst_n         (rst_n),
      .clr           (soft_rst),
      .host_load     (wr_acc && bus_addr == RI_MPQ),
      .host_data     (bus_wdata),
      .seq_load      (seq_mp_load),
      .seq_head_only (seq_mp_head_only),
      .seq_data      (seq_mp_data),
      .pop           (rd_acc && bus_addr == RI_MPQ),
      .head          (mp_head)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd_acc) begin
         case (bus_addr)
            RI_CSR:   bus_rdata <= cs_view;
            RI_BADDR: bus_rdata <= ba;
            RI_BCNT:  bus_rdata <= bc;
            RI_DADDR: bus_rdata <= da;
            RI_MPQ:   bus_rdata <= mp_head;
            default:  bus_rdata <= '0;
         endcase
      end
   end

   assign cmd_func  = cs_q[CS_FUNC_LO +: 3];
   assign cmd_drive = cs_q[CS_DRV_LO +: 2];

endmodule

// File: rtl/dskc_regbank_chk.sv
`timescale 1ns/1ps
module dskc_regbank_chk #(
   parameter int BA_BITS = 18
)(
   input logic        clk,
   input logic        rst_n,
   input logic        bus_sel,
   input logic        bus_wr,
   input logic [2:0]  bus_addr,
   input logic [31:0] bus_wdata,
   input logic [31:0] bus_rdata,
   input logic        seq_done,
   input logic        cmd_start,
   input logic        irq
);

   AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> $past(bus_sel && bus_wr && bus_addr == 3'd0 && !bus_wdata[7])); // R6

   AST_BADDR_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_sel && !bus_wr && bus_addr == 3'd1) |-> ((bus_rdata >> BA_BITS) == 32'h0)); // R9

   AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_sel && !bus_wr && (bus_addr == 3'd5 || bus_addr == 3'd6)) |-> (bus_rdata == 32'h0)); // R11

   AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(seq_done)); // R7

   AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_sel && bus_wr && bus_addr == 3'd7) |-> (!irq && !cmd_start)); // R1

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_sel && !bus_wr) |-> $stable(bus_rdata)); // R12

endmodule

bind dskc_regbank dskc_regbank_chk #(.BA_BITS(BA_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .seq_done  (seq_done),
   .cmd_start (cmd_start),
   .irq       (irq)
);

// File: tb/dskc_regbank_test.sv
`timescale 1ns/1ps
module dskc_regbank_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  drv_busy = 4'b0000;
   logic [3:0]  drv_enabled = 4'b0111;
   logic [3:0]  drv_is_large = 4'b0001;
   logic        seq_done = 1'b0;
   logic [4:0]  seq_err = '0;
   logic [3:0]  seq_atn = '0;
   logic        seq_sticky = 1'b0;
   logic        seq_mp_load = 1'b0, seq_mp_head_only = 1'b0;
   logic [31:0] seq_mp_data = '0;
   logic        cmd_start, irq;
   logic [2:0]  cmd_func;
   logic [1:0]  cmd_drive;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   dskc_regbank uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .drv_busy(drv_busy), .drv_enabled(drv_enabled), .drv_is_large(drv_is_large),
      .seq_done(seq_done), .seq_err(seq_err), .seq_atn(seq_atn),
      .seq_sticky(seq_sticky), .seq_mp_load(seq_mp_load),
      .seq_mp_head_only(seq_mp_head_only), .seq_mp_data(seq_mp_data),
      .cmd_start(cmd_start), .cmd_func(cmd_func), .cmd_drive(cmd_drive), .irq(irq)
   );

   typedef struct packed {
      logic        wr;
      logic [2:0]  a;
      logic [31:0] d;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VT [NV] = '{
      '{1'b0, 3'd0, 32'h0,         32'h0400_0081, 4'd2},  // R2 reset CSR, drive 0 large
      '{1'b1, 3'd1, 32'hFFFF_FFFF, 32'h0,         4'd9},
      '{1'b0, 3'd1, 32'h0,         32'h0003_FFFF, 4'd9},  // R9 18-bit address
      '{1'b1, 3'd2, 32'h1234_5678, 32'h0,         4'd9},
      '{1'b0, 3'd2, 32'h0,         32'h1234_5678, 4'd9},
      '{1'b1, 3'd3, 32'hCAFE_0102, 32'h0,         4'd9},
      '{1'b0, 3'd3, 32'h0,         32'hCAFE_0102, 4'd9},
      '{1'b1, 3'd4, 32'hA5A5_0001, 32'h0,         4'd10},
      '{1'b0, 3'd4, 32'h0,         32'hA5A5_0001, 4'd10}, // R10 all entries loaded
      '{1'b0, 3'd4, 32'h0,         32'hA5A5_0001, 4'd10},
      '{1'b0, 3'd4, 32'h0,         32'hA5A5_0001, 4'd10}, // tail repeats
      '{1'b1, 3'd5, 32'hFFFF_FFFF, 32'h0,         4'd11},
      '{1'b0, 3'd5, 32'h0,         32'h0,         4'd11}, // R11
      '{1'b1, 3'd6, 32'hFFFF_FFFF, 32'h0,         4'd11},
      '{1'b0, 3'd6, 32'h0,         32'h0,         4'd11},
      '{1'b1, 3'd0, 32'h0000_01C6, 32'h0,         4'd3},
      '{1'b0, 3'd0, 32'h0,         32'h0000_01C7, 4'd3},  // R3 fields, drive 1 small
      '{1'b0, 3'd1, 32'h0,         32'h0003_FFFF, 4'd9}
   };

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input int r, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %08h expected %08h", r, what, act, exp);
      end
   endtask

   // called and returns at a falling edge; outputs valid on return
   task automatic bus_op(input logic w, input logic [2:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic seq_complete(input logic [4:0] e, input logic [3:0] at);
      seq_done = 1'b1; seq_err = e; seq_atn = at;
      @(negedge clk);
      seq_done = 1'b0; seq_err = '0; seq_atn = '0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check({31'h0, irq}, 32'h0, 1, "irq after reset");          // R1
      check({31'h0, cmd_start}, 32'h0, 1, "start after reset");   // R1

      for (int i = 0; i < NV; i++) begin
         bus_op(VT[i].wr, VT[i].a, VT[i].d);
         if (!VT[i].wr) check(bus_rdata, VT[i].exp, int'(VT[i].req), $sformatf("table %0d", i));
      end

      // R12: a write does not disturb the last read data
      bus_op(1'b1, 3'd2, 32'h0BAD_0BAD);
      check(bus_rdata, 32'h0003_FFFF, 12, "rdata hold across write");

      // R6 command start
      bus_op(1'b1, 3'd0, 32'h0000_0146);
      check({31'h0, cmd_start}, 32'h1, 6, "start pulse");
      check({29'h0, cmd_func}, 32'h3, 6, "start func");
      check({30'h0, cmd_drive}, 32'h1, 6, "start drive");
      @(negedge clk);
      check({31'h0, cmd_start}, 32'h0, 6, "start one cycle");

      // R7 completion with header-style error and attention 1
      seq_complete(5'b00101, 4'b0010);
      check({31'h0, irq}, 32'h1, 7, "irq on done with IE");
      bus_op(1'b0, 3'd0, 32'h0);
      check(bus_rdata, 32'h0102_95C7, 8, "done flags and summary");  // R7 R8

      // R4 mode clear: write 1 to attention 1
      bus_op(1'b1, 3'd0, 32'h0002_01C6);
      check({31'h0, irq}, 32'h0, 4, "irq dropped by attention write");
      check({31'h0, cmd_start}, 32'h0, 6, "no start with DONE=1");
      bus_op(1'b0, 3'd0, 32'h0);
      check(bus_rdata, 32'h0100_95C7, 4, "attention cleared");

      seq_complete(5'b00000, 4'b0001);
      check({31'h0, irq}, 32'h1, 7, "irq on second done");
      bus_op(1'b1, 3'd0, 32'h8000_01C6);
      check({31'h0, irq}, 32'h1, 4, "irq kept without attention bits");
      bus_op(1'b1, 3'd0, 32'h8101_01C6);
      check({31'h0, irq}, 32'h0, 4, "irq dropped in mask mode");
      bus_op(1'b0, 3'd0, 32'h0);
      check(bus_rdata, 32'h8001_95C7, 4, "mask mode clears IRQ flag only");

      // R5 sticky flag
      seq_sticky = 1'b1; @(negedge clk); seq_sticky = 1'b0;
      bus_op(1'b1, 3'd0, 32'h8080_01C6);
      bus_op(1'b0, 3'd0, 32'h0);
      check(bus_rdata, 32'h8081_95C7, 5, "sticky kept by write 1");
      bus_op(1'b1, 3'd0, 32'h8000_01C6);
      bus_op(1'b0, 3'd0, 32'h0);
      check(bus_rdata, 32'h8001_95C7, 5, "sticky cleared by write 0");

      // R6 start clears errors except data-late
      bus_op(1'b1, 3'd0, 32'h8000_0146);
      check({31'h0, cmd_start}, 32'h1, 6, "second start");
      bus_op(1'b0, 3'd0, 32'h0);
      check(bus_rdata, 32'h8001_1147, 6, "errors cleared on start");

      // R6 busy drive: no start, errors kept; R2 busy reads not ready
      seq_complete(5'b00010, 4'b0000);
      drv_busy = 4'b0010;
      bus_op(1'b1, 3'd0, 32'h8000_0146);
      check({31'h0, cmd_start}, 32'h0, 6, "no start on busy drive");
      check({31'h0, irq}, 32'h1, 6, "irq kept on busy drive");
      bus_op(1'b0, 3'd0, 32'h0);
      check(bus_rdata, 32'h8101_9946, 2, "busy drive not ready");
      drv_busy = 4'b0000;

      // R2 disabled drive 3
      bus_op(1'b1, 3'd0, 32'h8000_03C6);
      bus_op(1'b0, 3'd0, 32'h0);
      check(bus_rdata, 32'h8101_9BC6, 2, "disabled drive not ready");

      // R10 sequencer head-only load then ripple
      seq_mp_load = 1'b1; seq_mp_head_only = 1'b1; seq_mp_data = 32'h0000_1111;
      @(negedge clk);
      seq_mp_load = 1'b0; seq_mp_head_only = 1'b0;
      bus_op(1'b0, 3'd4, 32'h0);
      check(bus_rdata, 32'h0000_1111, 10, "queue head");
      bus_op(1'b0, 3'd4, 32'h0);
      check(bus_rdata, 32'h0, 10, "queue second after shift");
      seq_mp_load = 1'b1; seq_mp_data = 32'h0000_2222;
      @(negedge clk);
      seq_mp_load = 1'b0;
      bus_op(1'b0, 3'd4, 32'h0);
      bus_op(1'b0, 3'd4, 32'h0);
      check(bus_rdata, 32'h0000_2222, 10, "full load second entry");

      // R1 soft reset via index 7
      bus_op(1'b1, 3'd7, 32'h0);
      check({31'h0, irq}, 32'h0, 1, "irq after soft reset");
      bus_op(1'b0, 3'd1, 32'h0);
      check(bus_rdata, 32'h0, 1, "address after soft reset");
      bus_op(1'b0, 3'd2, 32'h0);
      check(bus_rdata, 32'h0, 1, "count after soft reset");
      bus_op(1'b0, 3'd3, 32'h0);
      check(bus_rdata, 32'h0, 1, "disk address after soft reset");
      bus_op(1'b0, 3'd4, 32'h0);
      check(bus_rdata, 32'h0, 1, "queue after soft reset");
      bus_op(1'b0, 3'd0, 32'h0);
      check(bus_rdata, 32'h0400_0081, 1, "status after soft reset");

      summary();
      $finish;
   end

endmodule